// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block turns a handful of network-controller status events into one interrupt line that the host can mask. Each event arrives as a single-cycle set pulse and is held in an 8-bit status vector until that bit's own clear rule fires. The receiver-inhibited and transmitter-available bits are cleared only by their event source. The reconfiguration bit is cleared only by the clear-flags command strobe. The excessive-NAK bit is cleared only by the power-on clear-flags command strobe. The new-next-ID bit is cleared when the host reads the next-ID register.

The host writes an 8-bit mask whose bit positions match the status bits; a 1 enables that bit. The interrupt output is registered and is the OR of all enabled pending bits. Clearing a mask bit hides a pending flag but does not discard it. Setting the mask bit again raises the interrupt once more if the flag is still pending.

Each status bit is held by its own two-state machine. State FLAG_IDLE moves to FLAG_PENDING when its set pulse arrives. State FLAG_PENDING moves back to FLAG_IDLE when the bit's clear condition holds and no set pulse arrives in the same cycle. The interrupt line is a two-state machine as well. It moves from IRQ_QUIET to IRQ_RAISED when any enabled status bit is pending, and from IRQ_RAISED to IRQ_QUIET when none is.

Top module: `irq_status_ctrl`

## Requirements
- R1: A set pulse makes its status bit read 1 at the first output sample after the sampling edge. The bit positions are: receiver inhibited at bit 7, excessive NAK at bit 3, reconfiguration at bit 2, new next ID at bit 1, and transmitter available at bit 0.
- R2: `irq_o` is active high and registered. After a clock edge it equals the OR over all bits of (status AND mask), using the status and mask values that were present before that edge.
- R3: A mask write stores all 8 bits of `mask_wr_data`, and `mask_o` reads that value back after the edge that samples the write.
- R4: Clearing a mask bit drops the interrupt but leaves the status bit pending. Setting the mask bit again re-raises the interrupt while the status bit is still pending.
- R5: The reconfiguration bit is cleared by `cmd_clear_flags` and by nothing else.
- R6: The excessive-NAK bit is cleared by `cmd_por_clear` and by nothing else.
- R7: The new-next-ID bit is cleared by `next_id_rd`.
- R8: The receiver-inhibited and transmitter-available bits are cleared only by `src_clr_rx_inhibit` and `src_clr_tx_avail` respectively. Neither command strobe clears them.
- R9: When a set pulse and that bit's clear condition arrive in the same cycle, the bit ends up set.
- R10: Status bits 6 to 4 always read 0 and never raise the interrupt, even when their mask bits are 1.
- R11: After reset the status reads 8'h00, the mask reads 8'h00 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_rx_inhibit | input | 1 | Set pulse for the receiver-inhibited flag |
| ev_next_id | input | 1 | Set pulse for the new-next-ID flag |
| ev_excess_nak | input | 1 | Set pulse for the excessive-NAK flag |
| ev_recon | input | 1 | Set pulse for the reconfiguration flag |
| ev_tx_avail | input | 1 | Set pulse for the transmitter-available flag |
| src_clr_rx_inhibit | input | 1 | Clear from the source of the receiver-inhibited flag |
| src_clr_tx_avail | input | 1 | Clear from the source of the transmitter-available flag |
| mask_wr_en | input | 1 | Host mask write strobe |
| mask_wr_data | input | 8 | Host mask write data |
| cmd_clear_flags | input | 1 | Decoded clear-flags command strobe |
| cmd_por_clear | input | 1 | Decoded power-on clear-flags command strobe |
| next_id_rd | input | 1 | Strobe for a host read of the next-ID register |
| status_o | output | 8 | Live status bits |
| mask_o | output | 8 | Mask readback |
| irq_o | output | 1 | Registered interrupt |

## Verification
Two things can fall in the same cycle for one flag: its set pulse and its clear rule. The bench provokes this for all four clear mechanisms. It drives the reconfiguration event together with the clear-flags command, the excessive-NAK event together with the power-on clear, the next-ID event together with the next-ID read, and the receiver-inhibited event together with its source clear. Each case is judged by reading the status bit after the edge, which must be 1. One cycle later the bench checks that the interrupt reflects the pending flag under the current mask.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int unsigned STAT_W       = 8;
    localparam int unsigned POS_RX_INH   = 7;
    localparam int unsigned POS_XNAK     = 3;
    localparam int unsigned POS_RECON    = 2;
    localparam int unsigned POS_NEXT_ID  = 1;
    localparam int unsigned POS_TX_AVAIL = 0;

    // how a held flag may be dropped
    typedef enum logic [2:0] {
        CLR_BY_SOURCE  = 3'd0,
        CLR_BY_CMD     = 3'd1,
        CLR_BY_POR_CMD = 3'd2,
        CLR_BY_READ    = 3'd3,
        CLR_UNUSED     = 3'd4
    } clr_rule_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic clr_rule_e rule_of(input int unsigned idx);
        clr_rule_e r;
        case (idx)
            POS_RX_INH, POS_TX_AVAIL: r = CLR_BY_SOURCE;
            POS_RECON:                r = CLR_BY_CMD;
            POS_XNAK:                 r = CLR_BY_POR_CMD;
            POS_NEXT_ID:              r = CLR_BY_READ;
            default:                  r = CLR_UNUSED;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_status_pkg::*;
#(
    parameter clr_rule_e RULE = CLR_BY_SOURCE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic src_clr_i,
    input  logic cmd_clr_i,
    input  logic por_clr_i,
    input  logic rd_clr_i,
    output logic pending_o
);

    localparam bit IMPLEMENTED = (RULE != CLR_UNUSED);

    flag_state_e state_q, state_d;
    logic        set_hit;
    logic        clr_hit;

    // pick the one clear source this flag obeys
    always_comb begin
        set_hit = set_i && IMPLEMENTED;
        case (RULE)
            CLR_BY_SOURCE:  clr_hit = src_clr_i;
            CLR_BY_CMD:     clr_hit = cmd_clr_i;
            CLR_BY_POR_CMD: clr_hit = por_clr_i;
            CLR_BY_READ:    clr_hit = rd_clr_i;
            default:        clr_hit = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_hit) state_d = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                // a set in the same cycle beats the clear
                if (!set_hit && clr_hit) state_d = FLAG_IDLE;
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending_o = (state_q == FLAG_PENDING);
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_status_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    irq_state_e state_q, state_d;
    logic       any_enabled;

    always_comb begin
        any_enabled = |(status_i & mask_i);
        state_d     = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_enabled)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_enabled) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_rx_inhibit,
    input  logic       ev_next_id,
    input  logic       ev_excess_nak,
    input  logic       ev_recon,
    input  logic       ev_tx_avail,
    input  logic       src_clr_rx_inhibit,
    input  logic       src_clr_tx_avail,
    input  logic       mask_wr_en,
    input  logic [7:0] mask_wr_data,
    input  logic       cmd_clear_flags,
    input  logic       cmd_por_clear,
    input  logic       next_id_rd,
    output logic [7:0] status_o,
    output logic [7:0] mask_o,
    output logic       irq_o
);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] src_clr_vec;
    logic [STAT_W-1:0] status_w;
    logic [STAT_W-1:0] mask_w;

    always_comb begin
        set_vec                   = '0;
        set_vec[POS_RX_INH]       = ev_rx_inhibit;
        set_vec[POS_XNAK]         = ev_excess_nak;
        set_vec[POS_RECON]        = ev_recon;
        set_vec[POS_NEXT_ID]      = ev_next_id;
        set_vec[POS_TX_AVAIL]     = ev_tx_avail;
        src_clr_vec               = '0;
        src_clr_vec[POS_RX_INH]   = src_clr_rx_inhibit;
        src_clr_vec[POS_TX_AVAIL] = src_clr_tx_avail;
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        irq_flag_cell #(
            .RULE (rule_of(i))
        ) cell_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[i]),
            .src_clr_i (src_clr_vec[i]),
            .cmd_clr_i (cmd_clear_flags),
            .por_clr_i (cmd_por_clear),
            .rd_clr_i  (next_id_rd),
            .pending_o (status_w[i])
        );
    end

    irq_mask_reg #(
        .W (STAT_W)
    ) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .mask_o  (mask_w)
    );

    irq_combiner #(
        .W (STAT_W)
    ) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .mask_i   (mask_w),
        .irq_o    (irq_o)
    );

    assign status_o = status_w;
    assign mask_o   = mask_w;

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rx_inhibit,
    input logic       ev_next_id,
    input logic       ev_excess_nak,
    input logic       ev_recon,
    input logic       src_clr_rx_inhibit,
    input logic       mask_wr_en,
    input logic [7:0] mask_wr_data,
    input logic       cmd_clear_flags,
    input logic       cmd_por_clear,
    input logic       next_id_rd,
    input logic [7:0] status_o,
    input logic [7:0] mask_o,
    input logic       irq_o
);

    p_irq_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |($past(status_o) & $past(mask_o)));

    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> mask_o == $past(mask_wr_data));

    p_recon_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] && !cmd_clear_flags) |=> status_o[2]);

    p_xnak_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3] && !cmd_por_clear) |=> status_o[3]);

    p_nid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (next_id_rd && !ev_next_id) |=> !status_o[1]);

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !src_clr_rx_inhibit) |=> status_o[7]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_recon || ev_excess_nak) |=> (status_o[2] || !$past(ev_recon))
                                     && (status_o[3] || !$past(ev_excess_nak)));

    p_rx_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_inhibit |=> status_o[7]);

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

endmodule

bind irq_status_ctrl irq_status_ctrl_chk chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .ev_rx_inhibit      (ev_rx_inhibit),
    .ev_next_id         (ev_next_id),
    .ev_excess_nak      (ev_excess_nak),
    .ev_recon           (ev_recon),
    .src_clr_rx_inhibit (src_clr_rx_inhibit),
    .mask_wr_en         (mask_wr_en),
    .mask_wr_data       (mask_wr_data),
    .cmd_clear_flags    (cmd_clear_flags),
    .cmd_por_clear      (cmd_por_clear),
    .next_id_rd         (next_id_rd),
    .status_o           (status_o),
    .mask_o             (mask_o),
    .irq_o              (irq_o)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ev_rx_inhibit, ev_next_id, ev_excess_nak, ev_recon, ev_tx_avail;
    logic       src_clr_rx_inhibit, src_clr_tx_avail;
    logic       mask_wr_en;
    logic [7:0] mask_wr_data;
    logic       cmd_clear_flags, cmd_por_clear, next_id_rd;
    logic [7:0] status_o, mask_o;
    logic       irq_o;

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;
    logic [7:0] exp_status = 8'h00;
    logic [7:0] exp_mask   = 8'h00;

    always #4 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .ev_rx_inhibit      (ev_rx_inhibit),
        .ev_next_id         (ev_next_id),
        .ev_excess_nak      (ev_excess_nak),
        .ev_recon           (ev_recon),
        .ev_tx_avail        (ev_tx_avail),
        .src_clr_rx_inhibit (src_clr_rx_inhibit),
        .src_clr_tx_avail   (src_clr_tx_avail),
        .mask_wr_en         (mask_wr_en),
        .mask_wr_data       (mask_wr_data),
        .cmd_clear_flags    (cmd_clear_flags),
        .cmd_por_clear      (cmd_por_clear),
        .next_id_rd         (next_id_rd),
        .status_o           (status_o),
        .mask_o             (mask_o),
        .irq_o              (irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ev_rx_inhibit = 0; ev_next_id = 0; ev_excess_nak = 0; ev_recon = 0;
        ev_tx_avail = 0; src_clr_rx_inhibit = 0; src_clr_tx_avail = 0;
        mask_wr_en = 0; mask_wr_data = 8'h00;
        cmd_clear_flags = 0; cmd_por_clear = 0; next_id_rd = 0;
    endtask

    // one cycle: ev bits at status positions (7,3,2,1,0); sc bits 7/0 are source clears
    task automatic step(input string req, input logic [7:0] ev, input logic [7:0] sc,
                        input logic cclr, input logic cpor, input logic nrd,
                        input logic wen, input logic [7:0] wdat);
        logic exp_irq;
        exp_irq = |(exp_status & exp_mask);
        if (sc[7])   exp_status[7] = 1'b0;
        if (sc[0])   exp_status[0] = 1'b0;
        if (cclr)    exp_status[2] = 1'b0;
        if (cpor)    exp_status[3] = 1'b0;
        if (nrd)     exp_status[1] = 1'b0;
        exp_status = exp_status | (ev & 8'h8F);
        if (wen)     exp_mask = wdat;
        ev_rx_inhibit = ev[7]; ev_excess_nak = ev[3]; ev_recon = ev[2];
        ev_next_id = ev[1]; ev_tx_avail = ev[0];
        src_clr_rx_inhibit = sc[7]; src_clr_tx_avail = sc[0];
        cmd_clear_flags = cclr; cmd_por_clear = cpor; next_id_rd = nrd;
        mask_wr_en = wen; mask_wr_data = wdat;
        @(negedge clk);
        chk(req, "status", status_o, exp_status);
        chk(req, "mask", mask_o, exp_mask);
        chk(req, "irq", {7'b0, irq_o}, {7'b0, exp_irq});
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R11", "status", status_o, 8'h00);
        chk("R11", "mask", mask_o, 8'h00);
        chk("R11", "irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_set_each();
        step("R1", 8'h80, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R1", 8'h02, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R1", 8'h08, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R1", 8'h04, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R1", 8'h01, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R2", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic t_unused_bits();
        step("R10", 8'h00, 8'h00, 0, 0, 0, 1, 8'h70);
        step("R10", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R10", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic t_mask_hide();
        step("R3", 8'h00, 8'h00, 0, 0, 0, 1, 8'h80);
        step("R2", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R4", 8'h00, 8'h00, 0, 0, 0, 1, 8'h00);
        step("R4", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R4", 8'h00, 8'h00, 0, 0, 0, 1, 8'h81);
        step("R4", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic t_clear_rules();
        step("R3", 8'h00, 8'h00, 0, 0, 0, 1, 8'h0E);
        step("R6", 8'h00, 8'h00, 0, 1, 0, 0, 8'h00);
        step("R5", 8'h00, 8'h00, 0, 1, 0, 0, 8'h00);
        step("R7", 8'h00, 8'h00, 0, 0, 1, 0, 8'h00);
        step("R8", 8'h00, 8'h00, 1, 1, 1, 0, 8'h00);
        step("R5", 8'h00, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R2", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
        step("R8", 8'h00, 8'h80, 0, 0, 0, 0, 8'h00);
        step("R8", 8'h00, 8'h01, 0, 0, 0, 0, 8'h00);
        step("R11", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic t_set_wins();
        step("R9", 8'h04, 8'h00, 1, 0, 0, 0, 8'h00);
        step("R9", 8'h08, 8'h00, 0, 1, 0, 0, 8'h00);
        step("R9", 8'h02, 8'h00, 0, 0, 1, 0, 8'h00);
        step("R9", 8'h81, 8'h81, 0, 0, 0, 0, 8'h00);
        step("R9", 8'h00, 8'h00, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        @(negedge clk);
        t_set_each();
        t_unused_bits();
        t_mask_hide();
        t_clear_rules();
        t_set_wins();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule